// File: doc/BRIEF.md
# Look-ahead Unit-Lower-Triangular Solver over GF(2)

This block solves the linear system T·y = x over GF(2). T is a square N-by-N lower-triangular matrix with ones on its diagonal. It is fixed at elaboration and passed as a parameter. The right-hand side x streams in as groups of L bits. The solution y streams out as groups of L bits, one group per clock cycle when neither side stalls. No division or inversion is needed: every solution bit is its x bit XORed with a masked parity of the bits solved before it.

The bits of one group would normally form a serial chain, because bit r of the group depends on bits 0..r-1 of the same group. The block removes that chain by look-ahead. A small per-row combining table folds the earlier in-group equations into each later row, so a row's x term is an XOR of selected x bits of the same group. A second table holds each row's coefficients on previously solved bits, adjusted to match. Both tables are derived from T by constant functions at elaboration. A history register keeps the solved bits and feeds the next group's computation. The x-combining term and the history term are evaluated side by side and joined by one XOR.

Streams use valid/ready. An x group transfers on a clock edge where x_valid and x_ready are both high. A y group transfers where y_valid and y_ready are both high. While y_valid is high and y_ready is low, the output group is held and no new x group is taken. A solve begins with a start pulse while idle. It ends with a one-cycle done pulse after the last y group has left.

Top module: `lt_backsub`

## Requirements
- R1: While reset is asserted, y_valid, done and x_ready are all low.
- R2: While idle, x_ready is low and x_valid has no effect. A start pulse while idle begins a solve. Groups then transfer in ascending order: bit r of group g carries row g·L+r, for both x_data and y_data.
- R3: Each solution satisfies y0 = x0 and yi = xi XOR (XOR over j<i of t(i,j)·yj). Parameter T holds row i in bits [i·N +: N], with bit j of that slice being column j. Bits at j ≥ i are ignored, and the diagonal is taken as one.
- R4: An accepted x group appears as y_valid with its solution in the next cycle. With x_valid and y_ready held high, the N/L groups go in on consecutive cycles, and the last y group transfers N/L+1 cycles after the solve starts running. After the last x group, x_ready stays low.
- R5: While y_valid is high and y_ready is low, y_data stays stable, y_valid stays high and x_ready is low.
- R6: Cycles with x_valid low transfer nothing and do not change the result.
- R7: done is high for exactly one cycle: the cycle after the edge on which the last y group transferred. In that cycle the block is idle and x_ready is low.
- R8: A start pulse during a solve is ignored, and the solve completes with correct results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a solve when idle |
| x_valid | input | 1 | x group offered |
| x_ready | output | 1 | Block takes the x group this edge |
| x_data | input | L | Right-hand-side group, bit r = row g·L+r |
| y_valid | output | 1 | Solution group available |
| y_ready | input | 1 | Downstream takes the y group this edge |
| y_data | output | L | Solution group, bit r = row g·L+r |
| done | output | 1 | One-cycle pulse after the final y group |

## Verification
A wrong entry in either derived table, or a history bit written to the wrong column, corrupts the first group whose rows use that entry. It also spreads into every later row that depends on the bad bit. The error therefore shows on y_data the cycle after that group is accepted. One-hot right-hand sides over every row expose each column of the inverse separately, so a single bad coefficient points at its own row. A group-counter or handshake fault shows as a missing or extra done pulse, or as a wrong cycle count for an unstalled solve.

// File: rtl/lh_pkg.sv
package lh_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } lh_state_e;
endpackage

// File: rtl/lh_coef_rom.sv
// Constant tables derived from T: per-row x-combining bits and
// per-row adjusted coefficients on bits solved in earlier groups.
module lh_coef_rom #(
  parameter int N = 16,
  parameter int L = 4,
  parameter logic [N*N-1:0] T = '0,
  localparam int G  = N / L,
  localparam int GW = (G > 1) ? $clog2(G) : 1
) (
  input  logic [GW-1:0]    grp,
  output logic [L*L-1:0]   mix_rows,
  output logic [L*N-1:0]   adj_rows
);
  // Inverse of the in-group diagonal block, one L-bit row per matrix row.
  function automatic logic [N*L-1:0] mk_mix();
    logic [N*L-1:0] m;
    logic [L-1:0]   row;
    m = '0;
    for (int g = 0; g < G; g++) begin
      for (int r = 0; r < L; r++) begin
        row    = '0;
        row[r] = 1'b1;
        for (int c = 0; c < r; c++) begin
          if (T[(g*L+r)*N + g*L + c]) row = row ^ m[(g*L+c)*L +: L];
        end
        m[(g*L+r)*L +: L] = row;
      end
    end
    return m;
  endfunction

  // Coefficients on earlier-group bits after folding in-group equations.
  function automatic logic [N*N-1:0] mk_adj();
    logic [N*N-1:0] a;
    logic [N-1:0]   row;
    logic [N-1:0]   mask;
    a = '0;
    for (int g = 0; g < G; g++) begin
      mask = '0;
      for (int c = 0; c < g*L; c++) mask[c] = 1'b1;
      for (int r = 0; r < L; r++) begin
        row = T[(g*L+r)*N +: N] & mask;
        for (int c = 0; c < r; c++) begin
          if (T[(g*L+r)*N + g*L + c]) row = row ^ a[(g*L+c)*N +: N];
        end
        a[(g*L+r)*N +: N] = row;
      end
    end
    return a;
  endfunction

  localparam logic [N*L-1:0] MIX = mk_mix();
  localparam logic [N*N-1:0] ADJ = mk_adj();

  always_comb begin
    mix_rows = MIX[int'(grp)*L*L +: L*L];
    adj_rows = ADJ[int'(grp)*L*N +: L*N];
  end
endmodule

// File: rtl/lh_lane.sv
// One solution bit: combined x term XOR history term, evaluated in parallel.
module lh_lane #(
  parameter int N = 16,
  parameter int L = 4
) (
  input  logic [L-1:0] x_grp,
  input  logic [L-1:0] mix_row,
  input  logic [N-1:0] adj_row,
  input  logic [N-1:0] hist,
  output logic         y
);
  logic x_term;
  logic h_term;
  always_comb begin
    x_term = ^(mix_row & x_grp);
    h_term = ^(adj_row & hist);
    y      = x_term ^ h_term;
  end
endmodule

// File: rtl/lh_ctrl.sv
// Solve sequencing, stream handshakes, output register and done pulse.
module lh_ctrl #(
  parameter int N = 16,
  parameter int L = 4,
  localparam int G  = N / L,
  localparam int GW = (G > 1) ? $clog2(G) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          x_valid,
  output logic          x_ready,
  input  logic          y_ready,
  output logic          y_valid,
  output logic [L-1:0]  y_data,
  input  logic [L-1:0]  y_next,
  output logic          done,
  output logic [GW-1:0] grp,
  output logic          x_fire,
  output logic          clr
);
  import lh_pkg::*;

  lh_state_e    st_q;
  logic [GW-1:0] grp_q;
  logic          in_done_q;
  logic          yv_q;
  logic          ylast_q;
  logic [L-1:0]  yd_q;
  logic          done_q;
  logic          y_fire;
  logic          grp_last;

  always_comb begin
    grp_last = (grp_q == GW'(G-1));
    x_ready  = (st_q == ST_RUN) && !in_done_q && (!yv_q || y_ready);
    x_fire   = x_valid && x_ready;
    y_fire   = yv_q && y_ready;
    clr      = (st_q == ST_IDLE) && start;
    grp      = grp_q;
    y_valid  = yv_q;
    y_data   = yd_q;
    done     = done_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      grp_q     <= '0;
      in_done_q <= 1'b0;
      yv_q      <= 1'b0;
      ylast_q   <= 1'b0;
      yd_q      <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (clr) begin
        st_q      <= ST_RUN;
        grp_q     <= '0;
        in_done_q <= 1'b0;
      end
      if (x_fire) begin
        yd_q    <= y_next;
        yv_q    <= 1'b1;
        ylast_q <= grp_last;
        if (grp_last) in_done_q <= 1'b1;
        else          grp_q     <= grp_q + 1'b1;
      end else if (y_fire) begin
        yv_q <= 1'b0;
      end
      if (y_fire && ylast_q) begin
        st_q   <= ST_IDLE;
        done_q <= 1'b1;
      end
    end
  end

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (yv_q && !y_ready) |=> (yv_q && $stable(yd_q)));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  p_done_follows_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (y_fire && ylast_q) |=> (done_q && !x_ready));

  p_stop_after_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (x_fire && grp_last) |=> !x_ready);

  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_RUN) && start && !(y_fire && ylast_q)) |=> (st_q == ST_RUN));
endmodule

// File: rtl/lt_backsub.sv
module lt_backsub #(
  parameter int N = 16,
  parameter int L = 4,
  parameter logic [N*N-1:0] T = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         x_valid,
  output logic         x_ready,
  input  logic [L-1:0] x_data,
  output logic         y_valid,
  input  logic         y_ready,
  output logic [L-1:0] y_data,
  output logic         done
);
  localparam int G  = N / L;
  localparam int GW = (G > 1) ? $clog2(G) : 1;

  logic [GW-1:0]  grp;
  logic           x_fire;
  logic           clr;
  logic [L*L-1:0] mix_rows;
  logic [L*N-1:0] adj_rows;
  logic [N-1:0]   hist;
  logic [L-1:0]   y_next;

  lh_coef_rom #(.N(N), .L(L), .T(T)) u_rom (
    .grp      (grp),
    .mix_rows (mix_rows),
    .adj_rows (adj_rows)
  );

  for (genvar r = 0; r < L; r++) begin : g_lane
    lh_lane #(.N(N), .L(L)) u_lane (
      .x_grp   (x_data),
      .mix_row (mix_rows[r*L +: L]),
      .adj_row (adj_rows[r*N +: N]),
      .hist    (hist),
      .y       (y_next[r])
    );
  end

  // Solved bits, written at their own column positions.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hist <= '0;
    else if (clr)    hist <= '0;
    else if (x_fire) hist[int'(grp)*L +: L] <= y_next;
  end

  lh_ctrl #(.N(N), .L(L)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .x_valid (x_valid),
    .x_ready (x_ready),
    .y_ready (y_ready),
    .y_valid (y_valid),
    .y_data  (y_data),
    .y_next  (y_next),
    .done    (done),
    .grp     (grp),
    .x_fire  (x_fire),
    .clr     (clr)
  );
endmodule

// File: tb/tb_lt_backsub.sv
module tb_lt_backsub_run #(
  parameter int N = 16,
  parameter int L = 4,
  parameter logic [N*N-1:0] T = '0
) (
  input  logic clk,
  input  logic rst_n,
  output logic fin
);
  localparam int G = N / L;

  logic         start, x_valid, x_ready, y_valid, y_ready, done;
  logic [L-1:0] x_data, y_data;
  int checks = 0;
  int fails  = 0;

  lt_backsub #(.N(N), .L(L), .T(T)) dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .x_valid(x_valid), .x_ready(x_ready), .x_data(x_data),
    .y_valid(y_valid), .y_ready(y_ready), .y_data(y_data),
    .done(done)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s (L=%0d): actual %0h expected %0h", req, L, act, exp);
    end
  endtask

  // Forward substitution from the equations, one row at a time.
  function automatic logic [N-1:0] ref_solve(input logic [N-1:0] xv);
    logic [N-1:0] y;
    logic acc;
    y = '0;
    for (int i = 0; i < N; i++) begin
      acc = xv[i];
      for (int j = 0; j < i; j++) acc = acc ^ (T[i*N+j] & y[j]);
      y[i] = acc;
    end
    return y;
  endfunction

  task automatic run_vec(input logic [N-1:0] xv, input bit stall, input bit inj);
    logic [N-1:0] exp;
    logic [L-1:0] prev_data;
    bit prev_hold;
    int ins, outs, cyc;
    exp = ref_solve(xv);
    ins = 0; outs = 0; cyc = 0; prev_hold = 0; prev_data = '0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (outs < G && cyc < 12*G + 20) begin
      x_valid = (ins < G) && (!stall || ($urandom % 4 != 0));
      x_data  = (ins < G) ? xv[ins*L +: L] : '0;
      y_ready = !stall || ($urandom % 3 != 0);
      start   = inj && (ins == 1);
      #1;
      if (prev_hold) begin
        chk("R5 held valid", 64'(y_valid), 64'd1);
        chk("R5 held data", 64'(y_data), 64'(prev_data));
      end
      if (y_valid && !y_ready) chk("R5 x_ready low", 64'(x_ready), 64'd0);
      chk("R7 no early done", 64'(done), 64'd0);
      if (y_valid && y_ready) begin
        chk("R3 group value", 64'(y_data), 64'(exp[outs*L +: L]));
        outs++;
      end
      prev_hold = y_valid && !y_ready;
      prev_data = y_data;
      if (x_valid && x_ready) ins++;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0; x_valid = 1'b0; y_ready = 1'b0;
    chk("R4 all groups out", 64'(outs), 64'(G));
    if (!stall) chk("R4 cycle count", 64'(cyc), 64'(G+1));
    #1;
    chk("R7 done pulse", 64'(done), 64'd1);
    chk("R7 idle x_ready", 64'(x_ready), 64'd0);
    @(negedge clk);
    #1;
    chk("R7 done one cycle", 64'(done), 64'd0);
    chk("R7 no valid after", 64'(y_valid), 64'd0);
  endtask

  initial begin
    fin = 0; start = 0; x_valid = 0; y_ready = 0; x_data = '0;
    @(negedge clk);
    chk("R1 y_valid", 64'(y_valid), 64'd0);
    chk("R1 done", 64'(done), 64'd0);
    chk("R1 x_ready", 64'(x_ready), 64'd0);
    wait (rst_n);
    @(negedge clk);
    // R2: offers while idle are not taken
    x_valid = 1'b1; y_ready = 1'b1; x_data = '1;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk("R2 idle x_ready", 64'(x_ready), 64'd0);
      @(negedge clk);
      chk("R2 idle no output", 64'(y_valid), 64'd0);
    end
    x_valid = 1'b0;
    run_vec('0, 0, 0);
    run_vec('1, 0, 0);
    for (int i = 0; i < N; i++) run_vec(N'(1) << i, 0, 0);   // R3 columns of the inverse
    for (int k = 0; k < 30; k++) run_vec(N'({$urandom, $urandom}), 0, 0);
    for (int k = 0; k < 30; k++) run_vec(N'({$urandom, $urandom}), 1, 0); // R5 R6
    for (int k = 0; k < 6; k++)  run_vec(N'({$urandom, $urandom}), k[0], 1); // R8
    fin = 1;
  end
endmodule

module tb_lt_backsub;
  localparam int NB = 16;

  function automatic logic [NB*NB-1:0] gen_t(input int unsigned seed);
    logic [NB*NB-1:0] t;
    int unsigned s;
    s = seed;
    for (int b = 0; b < NB*NB; b++) begin
      s = s ^ (s << 13);
      s = s ^ (s >> 17);
      s = s ^ (s << 5);
      t[b] = s[7];
    end
    return t;  // above-diagonal bits left random on purpose (R3)
  endfunction

  localparam logic [NB*NB-1:0] TB_T = gen_t(32'h1234_5678);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fin4, fin2;
  int   cyc = 0;
  int   wd_fail = 0;

  always #5 clk = ~clk;

  tb_lt_backsub_run #(.N(NB), .L(4), .T(TB_T)) u_l4 (.clk(clk), .rst_n(rst_n), .fin(fin4));
  tb_lt_backsub_run #(.N(NB), .L(2), .T(TB_T)) u_l2 (.clk(clk), .rst_n(rst_n), .fin(fin2));

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
  end

  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    while (!(fin4 && fin2) && cyc < 150000) @(negedge clk);
    if (!(fin4 && fin2)) begin
      wd_fail = 1;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures",
             u_l4.checks + u_l2.checks + wd_fail,
             u_l4.fails + u_l2.fails + wd_fail);
    $finish;
  end
endmodule